// File: doc/BRIEF.md
# Auto-Incrementing Transfer Buffer Port

This block holds the data staging memory that sits between a host register bus and a byte-serial transfer engine. The memory is 128 words of 32 bits, which is 512 bytes. The host moves whole words through one data register. A control register sets the direction of the host's traffic and holds the current word address. When auto-increment is on, that address moves forward by itself after each access that takes effect, so software can stream a whole buffer through one register. The engine sees the same storage as bytes. It uses its own byte pointer, which software loads through an offset register and which steps forward once for each byte the engine moves.

A typical outbound transfer has four steps. Software sets host-write direction with auto-increment and word address 0. It then pushes the payload words, loads the engine offset with 0, and lets the engine pull bytes. For inbound data the engine fills the buffer first, and software then drains it in host-read direction. A payload longer than 512 bytes has to be split into several passes.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset, the control register reads 0, the engine pointer `eng_ptr_o` is 0, and reading the offset register returns 0.
- R2: The control register has three fields. Bit 31 is the direction: 1 means the host writes the buffer, 0 means the host reads it. Bit 30 enables auto-increment. Bits 7:0 hold the word address. Every control write reloads all three fields. On readback, bits 29:8 are 0. Register selects on `reg_sel_i` are: 0 control, 1 data, 2 engine offset, 3 unused (reads 0, writes ignored).
- R3: In host-write direction, a data register write stores the 32-bit word at the current word address. In host-read direction, a data register read returns the word stored there.
- R4: When auto-increment is on, each data access that takes effect advances the word address by 1. When it is off, the address holds.
- R5: The word address steps from 127 to 0.
- R6: Word addresses 128 to 255 hold no storage. Reads there return 0, and writes there change no stored byte.
- R7: In host-write direction, a data register read returns 0 and leaves the word address unchanged.
- R8: In host-read direction, a data register write is ignored. Stored data and the word address stay unchanged.
- R9: A write to the offset register loads the engine pointer from bits 8:0. Each engine byte access (`eng_rd_i` or `eng_wr_i`) advances the pointer by 1, and the pointer steps from 511 to 0.
- R10: Bytes are packed little-endian. Byte address 4*w+k is bits 8k+7:8k of word w. An engine read returns the byte at the pointer on `eng_rdata_o` in the cycle after the request.
- R11: When a host word write and an engine byte write hit the same word in the same cycle, the host word wins for all four bytes. When they hit different words, both writes take effect.
- R12: `reg_rdata_o` updates in the cycle after a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, registered |
| eng_rd_i | input | 1 | Engine byte read at pointer |
| eng_wr_i | input | 1 | Engine byte write at pointer |
| eng_wdata_i | input | 8 | Engine write byte |
| eng_rdata_o | output | 8 | Engine read byte, registered |
| eng_ptr_o | output | 9 | Engine byte pointer |

## Verification
The hardest case to reach from the ports is a host word write and an engine byte write landing in the same clock cycle. Normal software sequencing never overlaps the two. The bench therefore has a directed step that raises both strobes on the same edge, once aimed at a single word and once at neighbouring words. The next hardest cases are the address wrap from 127 to 0 and the unused upper address range. These are reached by streaming a full 128-word pass with auto-increment on, and by seeding control writes with addresses just above 127. After that, seeded random mixes of all operations run against a byte-level reference model.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_EOFF = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned DIR_BIT  = 31;
  localparam int unsigned AUTO_BIT = 30;
endpackage

// File: rtl/xbp_host_ctrl.sv
module xbp_host_ctrl #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_wr_i,
  input  logic          dir_i,
  input  logic          auto_i,
  input  logic [AW-1:0] addr_i,
  input  logic          data_acc_i,
  input  logic          data_write_i,
  output logic          dir_o,
  output logic          auto_o,
  output logic [AW-1:0] addr_o,
  output logic          in_range_o,
  output logic          word_we_o
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic          dir_q, auto_q;
  logic [AW-1:0] addr_q, addr_nxt;
  logic          eff;

  // access takes effect only when it matches the latched direction
  assign eff        = data_acc_i && (data_write_i == dir_q);
  assign in_range_o = (addr_q <= LAST);
  assign addr_nxt   = (addr_q == LAST) ? '0 : addr_q + 1'b1;
  assign word_we_o  = eff && data_write_i && in_range_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      auto_q <= 1'b0;
      addr_q <= '0;
    end else if (ctrl_wr_i) begin
      dir_q  <= dir_i;
      auto_q <= auto_i;
      addr_q <= addr_i;
    end else if (eff && auto_q) begin
      addr_q <= addr_nxt;
    end
  end

  assign dir_o  = dir_q;
  assign auto_o = auto_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/xbp_eng_ptr.sv
module xbp_eng_ptr #(
  parameter int unsigned PTR_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/xbp_store.sv
module xbp_store #(
  parameter int unsigned WORDS = 128,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned PTR_W = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             h_we_i,
  input  logic [IDX_W-1:0] h_idx_i,
  input  logic [31:0]      h_wdata_i,
  output logic [31:0]      h_rdata_o,
  input  logic             e_we_i,
  input  logic [PTR_W-1:0] e_addr_i,
  input  logic [7:0]       e_wdata_i,
  output logic [7:0]       e_rdata_o
);
  logic [IDX_W-1:0] e_idx;
  logic [1:0]       e_lane;
  logic [7:0]       lane_rd [4];

  assign e_idx  = e_addr_i[PTR_W-1:2];
  assign e_lane = e_addr_i[1:0];

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] mem_q [WORDS];

    // host write is applied last so it wins on a same-word collision
    always_ff @(posedge clk_i) begin
      if (e_we_i && (e_lane == 2'(ln))) mem_q[e_idx] <= e_wdata_i;
      if (h_we_i) mem_q[h_idx_i] <= h_wdata_i[8*ln +: 8];
    end

    assign h_rdata_o[8*ln +: 8] = mem_q[h_idx_i];
    assign lane_rd[ln]          = mem_q[e_idx];
  end

  assign e_rdata_o = lane_rd[e_lane];
endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port
  import xbp_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  parameter int unsigned AW    = 8,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned PTR_W = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_valid_i,
  input  logic             reg_write_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             eng_rd_i,
  input  logic             eng_wr_i,
  input  logic [7:0]       eng_wdata_i,
  output logic [7:0]       eng_rdata_o,
  output logic [PTR_W-1:0] eng_ptr_o
);
  reg_sel_e         sel;
  logic             ctrl_wr, eoff_wr, data_acc;
  logic             ctrl_dir, ctrl_auto, in_range, word_we;
  logic [AW-1:0]    ctrl_addr;
  logic [31:0]      word_rd, rd_mux, rdata_q;
  logic [7:0]       byte_rd, eng_rdata_q;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign ctrl_wr  = reg_valid_i && reg_write_i && (sel == SEL_CTRL);
  assign eoff_wr  = reg_valid_i && reg_write_i && (sel == SEL_EOFF);
  assign data_acc = reg_valid_i && (sel == SEL_DATA);

  xbp_host_ctrl #(.WORDS(WORDS), .AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr),
    .dir_i        (reg_wdata_i[DIR_BIT]),
    .auto_i       (reg_wdata_i[AUTO_BIT]),
    .addr_i       (reg_wdata_i[AW-1:0]),
    .data_acc_i   (data_acc),
    .data_write_i (reg_write_i),
    .dir_o        (ctrl_dir),
    .auto_o       (ctrl_auto),
    .addr_o       (ctrl_addr),
    .in_range_o   (in_range),
    .word_we_o    (word_we)
  );

  xbp_eng_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (eoff_wr),
    .load_val_i (reg_wdata_i[PTR_W-1:0]),
    .step_i     (eng_rd_i || eng_wr_i),
    .ptr_o      (eng_ptr_o)
  );

  xbp_store #(.WORDS(WORDS)) u_store (
    .clk_i     (clk_i),
    .h_we_i    (word_we),
    .h_idx_i   (ctrl_addr[IDX_W-1:0]),
    .h_wdata_i (reg_wdata_i),
    .h_rdata_o (word_rd),
    .e_we_i    (eng_wr_i),
    .e_addr_i  (eng_ptr_o),
    .e_wdata_i (eng_wdata_i),
    .e_rdata_o (byte_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = {ctrl_dir, ctrl_auto, {(30-AW){1'b0}}, ctrl_addr};
      SEL_DATA: rd_mux = (!ctrl_dir && in_range) ? word_rd : '0;
      SEL_EOFF: rd_mux = {{(32-PTR_W){1'b0}}, eng_ptr_o};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q     <= '0;
      eng_rdata_q <= '0;
    end else begin
      if (reg_valid_i && !reg_write_i) rdata_q <= rd_mux;
      if (eng_rd_i) eng_rdata_q <= byte_rd;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign eng_rdata_o = eng_rdata_q;
endmodule

// File: rtl/xfer_buf_port_chk.sv
module xfer_buf_port_chk #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned AW    = 8,
  parameter int unsigned PTR_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_valid_i,
  input logic             reg_write_i,
  input logic [1:0]       reg_sel_i,
  input logic [PTR_W-1:0] eoff_val_i,
  input logic [31:0]      reg_rdata_o,
  input logic             eng_rd_i,
  input logic             eng_wr_i,
  input logic [PTR_W-1:0] eng_ptr_o,
  input logic             dir_i,
  input logic             auto_i,
  input logic [AW-1:0]    waddr_i
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic data_rd, data_wr, eff, eoff_wr, reg_rd;
  assign reg_rd  = reg_valid_i && !reg_write_i;
  assign data_rd = reg_rd && (reg_sel_i == 2'd1);
  assign data_wr = reg_valid_i && reg_write_i && (reg_sel_i == 2'd1);
  assign eoff_wr = reg_valid_i && reg_write_i && (reg_sel_i == 2'd2);
  assign eff     = (data_rd && !dir_i) || (data_wr && dir_i);

  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff && auto_i && (waddr_i != LAST) |=> waddr_i == $past(waddr_i) + 1'b1);

  // R5
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff && auto_i && (waddr_i == LAST) |=> waddr_i == '0);

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && dir_i) || (data_wr && !dir_i) |=> $stable(waddr_i));

  // R7
  wdir_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd && dir_i |=> reg_rdata_o == '0);

  // R6
  high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd && !dir_i && (waddr_i > LAST) |=> reg_rdata_o == '0);

  // R9
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rd_i || eng_wr_i) && !eoff_wr |=> eng_ptr_o == $past(eng_ptr_o) + 1'b1);

  // R9
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoff_wr |=> eng_ptr_o == $past(eoff_val_i));

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd |=> $stable(reg_rdata_o));
endmodule

bind xfer_buf_port xfer_buf_port_chk #(.WORDS(WORDS), .AW(AW), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_valid_i (reg_valid_i),
  .reg_write_i (reg_write_i),
  .reg_sel_i   (reg_sel_i),
  .eoff_val_i  (reg_wdata_i[PTR_W-1:0]),
  .reg_rdata_o (reg_rdata_o),
  .eng_rd_i    (eng_rd_i),
  .eng_wr_i    (eng_wr_i),
  .eng_ptr_o   (eng_ptr_o),
  .dir_i       (ctrl_dir),
  .auto_i      (ctrl_auto),
  .waddr_i     (ctrl_addr)
);

// File: tb/xfer_buf_port_tb.sv
`timescale 1ns/1ps
module xfer_buf_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_rd = 1'b0, eng_wr = 1'b0;
  logic [7:0]  eng_wdata = '0;
  logic [7:0]  eng_rdata;
  logic [8:0]  eng_ptr;

  int checks = 0;
  int errors = 0;

  logic [7:0] ref_mem [512];
  int  m_addr = 0;
  bit  m_dir = 0, m_auto = 0;
  int  m_ptr = 0;

  always #2.5 clk = ~clk;

  xfer_buf_port u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_rd_i(eng_rd), .eng_wr_i(eng_wr), .eng_wdata_i(eng_wdata),
    .eng_rdata_o(eng_rdata), .eng_ptr_o(eng_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int next_addr(input int a);
    return (a == 127) ? 0 : ((a + 1) % 256);
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    if (a >= 128) return 32'h0;
    return {ref_mem[4*a+3], ref_mem[4*a+2], ref_mem[4*a+1], ref_mem[4*a]};
  endfunction

  task automatic bus(input bit wr, input logic [1:0] sel, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    r = reg_rdata;
  endtask

  task automatic ctrl_set(input bit dir, input bit aut, input int a);
    logic [31:0] r;
    bus(1'b1, 2'd0, {dir, aut, 22'h3F_FFFF, 8'(a)}, r);
    m_dir = dir; m_auto = aut; m_addr = a % 256;
  endtask

  task automatic chk_ctrl(input string req);
    logic [31:0] r;
    bus(1'b0, 2'd0, 32'h0, r);
    chk(req, r, {m_dir, m_auto, 22'h0, 8'(m_addr)});
  endtask

  task automatic model_word_wr(input logic [31:0] w);
    if (m_dir) begin
      if (m_addr < 128)
        for (int k = 0; k < 4; k++) ref_mem[4*m_addr+k] = w[8*k +: 8];
      if (m_auto) m_addr = next_addr(m_addr);
    end
  endtask

  task automatic host_wr(input logic [31:0] w);
    logic [31:0] r;
    bus(1'b1, 2'd1, w, r);
    model_word_wr(w);
  endtask

  task automatic host_rd(input string req);
    logic [31:0] r, e;
    bus(1'b0, 2'd1, 32'h0, r);
    if (m_dir) e = 32'h0;
    else begin
      e = exp_word(m_addr);
      if (m_auto) m_addr = next_addr(m_addr);
    end
    chk(req, r, e);
  endtask

  task automatic eoff(input int v);
    logic [31:0] r;
    bus(1'b1, 2'd2, 32'(v), r);
    m_ptr = v % 512;
  endtask

  task automatic eng_op(input bit wr, input logic [7:0] b, input string req);
    @(negedge clk);
    eng_rd = !wr; eng_wr = wr; eng_wdata = b;
    @(negedge clk);
    eng_rd = 1'b0; eng_wr = 1'b0;
    if (wr) ref_mem[m_ptr] = b;
    else chk(req, {24'h0, eng_rdata}, {24'h0, ref_mem[m_ptr]});
    m_ptr = (m_ptr + 1) % 512;
  endtask

  // host word write and engine byte write on the same edge
  task automatic collide(input logic [31:0] w, input logic [7:0] b);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_sel = 2'd1; reg_wdata = w;
    eng_wr = 1'b1; eng_wdata = b;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; eng_wr = 1'b0;
    ref_mem[m_ptr] = b;
    m_ptr = (m_ptr + 1) % 512;
    model_word_wr(w);
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    chk_ctrl("R1 ctrl reset");
    bus(1'b0, 2'd2, 32'h0, r);
    chk("R1 offset reset", r, 32'h0);
    chk("R1 ptr reset", {23'h0, eng_ptr}, 32'h0);

    // R2 readback masks the unused bits
    ctrl_set(1, 1, 8'h5A);
    chk_ctrl("R2 ctrl fields");
    bus(1'b0, 2'd3, 32'h0, r);
    chk("R2 unused select", r, 32'h0);

    // R3 R4 R5 fill full buffer, then drain
    ctrl_set(1, 1, 0);
    for (int i = 0; i < 128; i++) host_wr($urandom());
    chk_ctrl("R5 wrap after fill");
    ctrl_set(0, 1, 0);
    for (int i = 0; i < 128; i++) host_rd("R3 drain");
    chk_ctrl("R5 wrap after drain");

    // R4 hold without auto-increment
    ctrl_set(0, 0, 5);
    host_rd("R4 no inc a");
    host_rd("R4 no inc b");
    chk_ctrl("R4 addr held");

    // R6 unused words
    ctrl_set(1, 1, 130);
    host_wr(32'hDEAD_BEEF);
    chk_ctrl("R6 R4 step above range");
    ctrl_set(0, 0, 130);
    host_rd("R6 high read zero");
    ctrl_set(0, 0, 2);
    host_rd("R6 no alias word 2");

    // R7
    ctrl_set(1, 1, 9);
    host_rd("R7 read in write dir");
    chk_ctrl("R7 addr unchanged");

    // R8
    ctrl_set(0, 1, 9);
    bus(1'b1, 2'd1, 32'hCAFE_F00D, r);
    chk_ctrl("R8 addr unchanged");
    host_rd("R8 data unchanged");

    // R10 little-endian packing
    eoff(80);
    eng_op(1, 8'h11, ""); eng_op(1, 8'h22, ""); eng_op(1, 8'h33, ""); eng_op(1, 8'h44, "");
    chk("R9 ptr after bytes", {23'h0, eng_ptr}, 32'd84);
    ctrl_set(0, 0, 20);
    bus(1'b0, 2'd1, 32'h0, r);
    chk("R10 packed word", r, 32'h4433_2211);
    eoff(81);
    eng_op(0, 8'h0, "R10 engine read");

    // R9 pointer wrap
    eoff(510);
    eng_op(1, 8'hA5, ""); eng_op(1, 8'h5A, ""); eng_op(1, 8'hC3, "");
    chk("R9 ptr wrap", {23'h0, eng_ptr}, 32'd1);
    eoff(511);
    eng_op(0, 8'h0, "R9 read 511");
    eng_op(0, 8'h0, "R9 read 0");

    // R11 collisions
    ctrl_set(1, 0, 30);
    eoff(121);
    collide(32'hA1B2_C3D4, 8'hEE);
    ctrl_set(0, 0, 30);
    host_rd("R11 same word host wins");
    ctrl_set(1, 0, 30);
    eoff(124);
    collide(32'h0F1E_2D3C, 8'h77);
    ctrl_set(0, 1, 30);
    host_rd("R11 word 30");
    host_rd("R11 word 31 engine byte");

    // R12 read data holds across non-read accesses
    ctrl_set(0, 0, 40);
    bus(1'b0, 2'd1, 32'h0, held);
    chk("R12 read value", held, exp_word(40));
    eng_op(1, 8'h99, "");
    bus(1'b1, 2'd0, 32'h8000_0003, r);
    m_dir = 1; m_auto = 0; m_addr = 3;
    chk("R12 rdata held", reg_rdata, held);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0:       ctrl_set(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                          ($urandom_range(0, 9) == 0) ? $urandom_range(120, 140)
                                                      : $urandom_range(0, 127));
        1, 2:    host_wr($urandom());
        3, 4, 5: host_rd("R3 R4 random host read");
        6:       eng_op(1, 8'($urandom()), "");
        7, 8:    eng_op(0, 8'h0, "R10 random engine read");
        default: eoff($urandom_range(0, 511));
      endcase
      if (op == 0) chk_ctrl("R2 random ctrl");
    end
    chk("R9 final ptr", {23'h0, eng_ptr}, 32'(m_ptr));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule